// File: doc/BRIEF.md
# Pipelined Ray versus Box Slab Tester

This block is one sub-pipeline of a bounding-volume-hierarchy traversal engine. Each cycle it can take one ray and one or two axis-aligned boxes. It answers after a fixed number of cycles with hit flags, entry distances and the ray's next traversal state. The ray is given by its origin, the per-axis reciprocal of its direction and its live interval [tnear, tfar]. All values are signed fixed point with `FRAC` fraction bits, packed x in the low slice, then y, then z. An axis where the ray is parallel to the slabs must be given a reciprocal of large magnitude rather than zero.

There are two modes. In inner-node mode (`in_leaf`=0), box A is the left child and box B is the right child. The two children arrive together as one fetched pair and are tested in the same pass. The block also reports which hit child is nearer, so traversal can descend into that child first. In leaf mode (`in_leaf`=1), box A is the bounding box of one primitive, and a leaf is walked one primitive per pass. A primitive index and the leaf's primitive count travel with the ray. A primitive whose box misses is culled, so only hits are flagged for the exact intersection unit. The result says whether the leaf loop goes on or the ray moves to the stack step.

Top module: `raybox_pipe`

## Requirements
- R1: With `out_ready` held high, a ray accepted at a clock edge appears on `out_valid` exactly `LAT` (default 12) edges later. One ray can be accepted every cycle, and results leave in acceptance order.
- R2: While `out_valid`=1 and `out_ready`=0, every stage is frozen. All outputs hold their values and `in_ready` is 0, so no ray is lost or duplicated.
- R3: For each box, the entry distance is tmin and the exit distance is tmax. Per axis, t = ((plane − origin) × recip) >>> FRAC. tmin is the largest of tnear and each axis' smaller t. tmax is the smallest of tfar and each axis' larger t. The box hits when tmin ≤ tmax. A reported distance equals tmin on a hit and 0 on a miss.
- R4: The ray interval clips the test. A box lying wholly beyond tfar misses, and so does a box lying wholly before tnear. When the origin is inside a box, the entry distance is tnear.
- R5: In inner-node mode, `out_hit_a` reports box A (left) and `out_hit_b` reports box B (right), independently. Both, either or neither may be set.
- R6: `out_near_b`=1 exactly when box B hits and either box A misses or B's entry distance is strictly less than A's. On a tie, the left child wins.
- R7: In leaf mode, only box A is tested. `out_hit_b`, `out_near_b` and `out_t_b` are 0 whatever box B holds. `out_to_isect` equals `out_hit_a`, and `out_to_isect` is 0 in inner-node mode.
- R8: In leaf mode, `out_prim_idx` = index+1. `out_state` is 2'b01 (more primitives) when index+1 < count, and 2'b10 (go to the stack step) otherwise. In inner-node mode the index passes through unchanged and `out_state` is 2'b10. `out_prim_cnt` always echoes the count.
- R9: During and right after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input ray offered |
| in_ready | output | 1 | Input ray taken this cycle |
| in_leaf | input | 1 | 1 = leaf (primitive) mode, 0 = inner-node mode |
| in_org | input | 3*W | Ray origin {z,y,x} |
| in_inv | input | 3*W | Reciprocal direction {z,y,x} |
| in_tnear | input | W | Interval start |
| in_tfar | input | W | Interval end |
| in_box_a_lo | input | 3*W | Box A lower corner (left child or primitive box) |
| in_box_a_hi | input | 3*W | Box A upper corner |
| in_box_b_lo | input | 3*W | Box B lower corner (right child) |
| in_box_b_hi | input | 3*W | Box B upper corner |
| in_prim_idx | input | CW | Current primitive index |
| in_prim_cnt | input | CW | Primitive count of the leaf |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result taken this cycle |
| out_leaf | output | 1 | Mode of the result |
| out_hit_a | output | 1 | Box A hit |
| out_hit_b | output | 1 | Box B hit |
| out_t_a | output | W | Entry distance into box A |
| out_t_b | output | W | Entry distance into box B |
| out_near_b | output | 1 | Box B is the child to visit first |
| out_state | output | 2 | Next traversal state |
| out_prim_idx | output | CW | Updated primitive index |
| out_prim_cnt | output | CW | Primitive count echoed |
| out_to_isect | output | 1 | Forward this primitive to exact intersection |

## Verification
Back-pressure and intake meet in the same cycle when a result waits on a low `out_ready` while the next ray is already being offered. The bench streams rays back to back while a side process drops `out_ready` in a repeating pattern. It judges the outcome by checking that outputs hold, that `in_ready` stays low through every stalled cycle, and that each result still matches its ray in order. The leaf loop's ending and the cull decision also share a cycle. A leaf's last primitive that misses must report the stack step with no forward to intersection, and a middle primitive that hits must report a continuing loop with a forward.

// File: rtl/raybox_pipe.sv
module raybox_pipe #(
  parameter int W    = 16,
  parameter int FRAC = 8,
  parameter int CW   = 4,
  parameter int LAT  = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic            in_leaf,
  input  logic [3*W-1:0]  in_org,
  input  logic [3*W-1:0]  in_inv,
  input  logic [W-1:0]    in_tnear,
  input  logic [W-1:0]    in_tfar,
  input  logic [3*W-1:0]  in_box_a_lo,
  input  logic [3*W-1:0]  in_box_a_hi,
  input  logic [3*W-1:0]  in_box_b_lo,
  input  logic [3*W-1:0]  in_box_b_hi,
  input  logic [CW-1:0]   in_prim_idx,
  input  logic [CW-1:0]   in_prim_cnt,
  output logic            out_valid,
  input  logic            out_ready,
  output logic            out_leaf,
  output logic            out_hit_a,
  output logic            out_hit_b,
  output logic [W-1:0]    out_t_a,
  output logic [W-1:0]    out_t_b,
  output logic            out_near_b,
  output logic [1:0]      out_state,
  output logic [CW-1:0]   out_prim_idx,
  output logic [CW-1:0]   out_prim_cnt,
  output logic            out_to_isect
);
  localparam int DW    = W + 1;
  localparam int PW    = 2 * W + 1;
  localparam int SW    = 1 + 2 * CW + 2 * W;
  localparam int RW    = 7 + 2 * W + 2 * CW;
  localparam int DEPTH = LAT - 2;

  logic adv;
  assign adv      = !(out_valid && !out_ready);
  assign in_ready = adv;

  logic [12*W-1:0] planes;
  logic signed [W-1:0] pl [12];
  assign planes = {in_box_b_hi, in_box_b_lo, in_box_a_hi, in_box_a_lo};
  for (genvar k = 0; k < 12; k++) begin : g_pl
    assign pl[k] = planes[k*W +: W];
  end

  logic                 v1, v2;
  logic signed [DW-1:0] d1 [12];
  logic signed [W-1:0]  inv1 [3];
  logic signed [PW-1:0] t2 [12];
  logic [SW-1:0]        sb1, sb2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
    end else if (adv) begin
      v1 <= in_valid;
      v2 <= v1;
    end

  always_ff @(posedge clk)
    if (adv) begin
      for (int i = 0; i < 12; i++) begin
        d1[i] <= DW'(pl[i]) - DW'($signed(in_org[(i%3)*W +: W]));
        t2[i] <= (PW'(d1[i]) * PW'(inv1[i%3])) >>> FRAC;
      end
      for (int a = 0; a < 3; a++) inv1[a] <= in_inv[a*W +: W];
      sb1 <= {in_leaf, in_prim_idx, in_prim_cnt, in_tnear, in_tfar};
      sb2 <= sb1;
    end

  logic                leaf2;
  logic [CW-1:0]       idx2, cnt2;
  logic signed [W-1:0] tn2, tf2;
  assign {leaf2, idx2, cnt2, tn2, tf2} = sb2;

  logic [1:0]          hit;
  logic signed [W-1:0] tent [2];
  for (genvar b = 0; b < 2; b++) begin : g_box
    logic signed [PW-1:0] tmn, tmx, lo, hi;
    always_comb begin
      tmn = PW'(tn2);
      tmx = PW'(tf2);
      lo  = '0;
      hi  = '0;
      for (int a = 0; a < 3; a++) begin
        if (t2[b*6+a] < t2[b*6+3+a]) begin
          lo = t2[b*6+a];
          hi = t2[b*6+3+a];
        end else begin
          lo = t2[b*6+3+a];
          hi = t2[b*6+a];
        end
        if (lo > tmn) tmn = lo;
        if (hi < tmx) tmx = hi;
      end
    end
    assign hit[b]  = (tmn <= tmx);
    assign tent[b] = tmn[W-1:0];
  end

  logic          hit_a, hit_b, near_b;
  logic [CW:0]   nxt;
  logic [1:0]    st;
  logic [RW-1:0] r3;
  assign hit_a  = hit[0];
  assign hit_b  = !leaf2 && hit[1];
  assign near_b = hit_b && (!hit_a || (tent[1] < tent[0]));
  assign nxt    = leaf2 ? {1'b0, idx2} + (CW+1)'(1) : {1'b0, idx2};
  assign st     = (leaf2 && (nxt < {1'b0, cnt2})) ? 2'b01 : 2'b10;
  assign r3     = {leaf2, hit_a, hit_b, near_b,
                   hit_a ? tent[0] : W'(0), hit_b ? tent[1] : W'(0),
                   st, nxt[CW-1:0], cnt2, leaf2 && hit_a};

  logic [RW-1:0]    dq [DEPTH];
  logic [DEPTH-1:0] dv;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) dv <= '0;
    else if (adv) dv <= {dv[DEPTH-2:0], v2};

  always_ff @(posedge clk)
    if (adv) begin
      dq[0] <= r3;
      for (int i = 1; i < DEPTH; i++) dq[i] <= dq[i-1];
    end

  assign out_valid = dv[DEPTH-1];
  assign {out_leaf, out_hit_a, out_hit_b, out_near_b, out_t_a, out_t_b,
          out_state, out_prim_idx, out_prim_cnt, out_to_isect} = dq[DEPTH-1];
endmodule

// File: rtl/raybox_pipe_chk.sv
module raybox_pipe_chk #(
  parameter int W   = 16,
  parameter int CW  = 4,
  parameter int LAT = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic          out_leaf,
  input logic          out_hit_a,
  input logic          out_hit_b,
  input logic          out_near_b,
  input logic [W-1:0]  out_t_a,
  input logic [W-1:0]  out_t_b,
  input logic [1:0]    out_state,
  input logic [CW-1:0] out_prim_idx,
  input logic          out_to_isect
);
  localparam int OW = $clog2(LAT + 2) + 1;
  logic [OW-1:0] occ;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) occ <= '0;
    else occ <= occ + OW'(in_valid && in_ready) - OW'(out_valid && out_ready);

  a_r1_inflight_bound: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OW'(LAT));
  a_r1_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> occ != '0);
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid &&
      $stable({out_leaf, out_hit_a, out_hit_b, out_near_b, out_t_a, out_t_b,
               out_state, out_prim_idx, out_to_isect}));
  a_r2_no_intake: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  a_r3_miss_dist_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_hit_a |-> out_t_a == '0);
  a_r6_near_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_near_b |-> out_hit_b);
  a_r7_leaf_single_box: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_leaf |-> !out_hit_b && !out_near_b && out_t_b == '0);
  a_r7_isect_only_leaf_hit: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_to_isect |-> out_leaf && out_hit_a);
  a_r8_child_to_stack: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_leaf |-> out_state == 2'b10);
endmodule

bind raybox_pipe raybox_pipe_chk #(.W(W), .CW(CW), .LAT(LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_leaf(out_leaf),
  .out_hit_a(out_hit_a), .out_hit_b(out_hit_b), .out_near_b(out_near_b),
  .out_t_a(out_t_a), .out_t_b(out_t_b), .out_state(out_state),
  .out_prim_idx(out_prim_idx), .out_to_isect(out_to_isect)
);

// File: tb/raybox_pipe_bench.sv
`timescale 1ns/1ps
module raybox_pipe_bench;
  localparam int W = 16, FRAC = 8, CW = 4, LAT = 12;
  localparam int VW = 7 + 2*W + 2*CW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, in_leaf = 1'b0;
  logic [3*W-1:0] in_org = '0, in_inv = '0;
  logic [W-1:0] in_tnear = '0, in_tfar = '0;
  logic [3*W-1:0] in_box_a_lo = '0, in_box_a_hi = '0, in_box_b_lo = '0, in_box_b_hi = '0;
  logic [CW-1:0] in_prim_idx = '0, in_prim_cnt = '0;
  logic out_valid, out_ready = 1'b1, out_leaf, out_hit_a, out_hit_b, out_near_b, out_to_isect;
  logic [W-1:0] out_t_a, out_t_b;
  logic [1:0] out_state;
  logic [CW-1:0] out_prim_idx, out_prim_cnt;

  always #2.5 clk = ~clk;

  raybox_pipe #(.W(W), .FRAC(FRAC), .CW(CW), .LAT(LAT)) u_raybox_pipe (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_leaf(in_leaf),
    .in_org(in_org), .in_inv(in_inv), .in_tnear(in_tnear), .in_tfar(in_tfar),
    .in_box_a_lo(in_box_a_lo), .in_box_a_hi(in_box_a_hi),
    .in_box_b_lo(in_box_b_lo), .in_box_b_hi(in_box_b_hi),
    .in_prim_idx(in_prim_idx), .in_prim_cnt(in_prim_cnt),
    .out_valid(out_valid), .out_ready(out_ready), .out_leaf(out_leaf),
    .out_hit_a(out_hit_a), .out_hit_b(out_hit_b), .out_t_a(out_t_a), .out_t_b(out_t_b),
    .out_near_b(out_near_b), .out_state(out_state), .out_prim_idx(out_prim_idx),
    .out_prim_cnt(out_prim_cnt), .out_to_isect(out_to_isect)
  );

  int o[3], iv[3], al[3], ah[3], bl[3], bh[3];
  int tn, tf;
  logic [VW-1:0] exq[$];
  string tagq[$];
  int accq[$];
  int checks = 0, fails = 0, cyc = 0;
  bit lat_chk = 1'b0, done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic longint slab(int ln[3], int hn[3], output bit hit);
    longint mn, mx, t0, t1;
    mn = tn; mx = tf;
    for (int a = 0; a < 3; a++) begin
      t0 = ((longint'(ln[a]) - o[a]) * iv[a]) >>> FRAC;
      t1 = ((longint'(hn[a]) - o[a]) * iv[a]) >>> FRAC;
      if (t1 < t0) begin longint s = t0; t0 = t1; t1 = s; end
      if (t0 > mn) mn = t0;
      if (t1 < mx) mx = t1;
    end
    hit = (mn <= mx);
    return mn;
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic offer(bit leaf, int idx, int cnt, string tag);
    bit ha, hb, hbm, near, acc;
    longint ta, tb;
    int nx;
    logic [1:0] st;
    ta = slab(al, ah, ha);
    tb = slab(bl, bh, hb);
    hbm  = !leaf && hb;
    near = hbm && (!ha || tb < ta);
    nx = leaf ? idx + 1 : idx;
    st = (leaf && nx < cnt) ? 2'b01 : 2'b10;
    exq.push_back({leaf, ha, hbm, near, W'(ha ? ta : 0), W'(hbm ? tb : 0), st,
                   CW'(nx), CW'(cnt), leaf && ha});
    tagq.push_back(tag);
    in_leaf = leaf;
    in_org = {W'(o[2]), W'(o[1]), W'(o[0])};
    in_inv = {W'(iv[2]), W'(iv[1]), W'(iv[0])};
    in_tnear = W'(tn); in_tfar = W'(tf);
    in_box_a_lo = {W'(al[2]), W'(al[1]), W'(al[0])};
    in_box_a_hi = {W'(ah[2]), W'(ah[1]), W'(ah[0])};
    in_box_b_lo = {W'(bl[2]), W'(bl[1]), W'(bl[0])};
    in_box_b_hi = {W'(bh[2]), W'(bh[1]), W'(bh[0])};
    in_prim_idx = CW'(idx); in_prim_cnt = CW'(cnt);
    in_valid = 1'b1;
    do begin
      @(negedge clk); acc = in_ready;
      tick();
    end while (!acc);
  endtask

  task automatic drain();
    in_valid = 1'b0;
    while (exq.size() != 0) tick();
    tick();
  endtask

  task automatic base_ray();
    o = '{0, 0, 0}; iv = '{256, 256, 256}; tn = 0; tf = 25600;
    al = '{512, 512, 512};    ah = '{1024, 1024, 1024};
    bl = '{1536, 1536, 1536}; bh = '{2048, 2048, 2048};
  endtask

  logic [VW-1:0] act, prev;
  bit pstall = 1'b0;
  always @(negedge clk) if (rst_n) begin
    act = {out_leaf, out_hit_a, out_hit_b, out_near_b, out_t_a, out_t_b,
           out_state, out_prim_idx, out_prim_cnt, out_to_isect};
    if (in_valid && in_ready) accq.push_back(cyc);
    if (pstall) chk(out_valid && act === prev, "R2 hold", longint'(act), longint'(prev));
    if (out_valid && !out_ready) chk(!in_ready, "R2 intake", in_ready, 0);
    if (out_valid && out_ready) begin
      if (exq.size() == 0) chk(1'b0, "R1 unexpected output", 1, 0);
      else begin
        logic [VW-1:0] e;
        string t;
        int a;
        e = exq.pop_front(); t = tagq.pop_front(); a = accq.pop_front();
        chk(act === e, t, longint'(act), longint'(e));
        if (lat_chk) chk(cyc - a == LAT, "R1 latency", cyc - a, LAT);
      end
    end
    pstall = out_valid && !out_ready;
    prev = act;
  end

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) tick();
    chk(out_valid == 1'b0, "R9 out_valid in reset", out_valid, 0);
    chk(in_ready == 1'b1, "R9 in_ready in reset", in_ready, 1);
    rst_n = 1'b1;
    tick();
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R9 after reset", {out_valid, in_ready}, 1);
  endtask

  task automatic t_latency();
    lat_chk = 1'b1;
    base_ray();
    offer(0, 0, 0, "R1 single ray R5 R6 left nearer");
    drain();
    lat_chk = 1'b0;
  endtask

  task automatic t_children();
    base_ray();
    al = '{1536, 1536, 1536}; ah = '{2048, 2048, 2048};
    bl = '{512, 512, 512};    bh = '{1024, 1024, 1024};
    offer(0, 3, 0, "R6 right nearer");
    bl = al; bh = ah;
    offer(0, 0, 0, "R6 tie goes left");
    al = '{-1024, -1024, -1024}; ah = '{-512, -512, -512};
    offer(0, 0, 0, "R5 only right hits, R4 box behind");
    base_ray(); bl = '{-1024, -1024, -1024}; bh = '{-512, -512, -512};
    offer(0, 0, 0, "R5 only left hits");
    al = bl; ah = bh;
    offer(0, 0, 0, "R5 neither hits");
    drain();
  endtask

  task automatic t_interval();
    base_ray(); tf = 768;
    offer(0, 0, 0, "R4 right beyond tfar");
    base_ray(); o = '{768, 768, 768}; tn = 64;
    offer(0, 0, 0, "R4 origin inside gives tnear");
    base_ray(); iv = '{-256, -256, -256};
    al = '{-1024, -1024, -1024}; ah = '{-512, -512, -512};
    offer(0, 0, 0, "R3 negative reciprocal");
    base_ray(); iv = '{256, 512, 128};
    al = '{512, 2048, 0}; ah = '{1024, 2560, 256};
    bl = '{256, 128, 64}; bh = '{1024, 1024, 512};
    offer(0, 0, 0, "R3 mixed axes");
    drain();
  endtask

  task automatic t_leaf();
    base_ray();
    offer(1, 0, 3, "R7 R8 leaf prim0 hit");
    al = '{-1024, -1024, -1024}; ah = '{-512, -512, -512};
    offer(1, 1, 3, "R7 R8 leaf prim1 culled");
    base_ray(); al = bl; ah = bh;
    offer(1, 2, 3, "R8 leaf last prim hit");
    al = '{-1024, -1024, -1024}; ah = '{-512, -512, -512};
    offer(1, 0, 1, "R7 R8 last prim culled");
    drain();
  endtask

  task automatic t_stall();
    fork
      begin
        for (int i = 0; i < 12; i++) begin
          base_ray();
          if (i % 3 == 1) begin al = '{1536, 1536, 1536}; ah = '{2048, 2048, 2048}; end
          if (i % 4 == 2) tf = 768;
          offer(i % 2 == 1, i % 5, 4, "R2 stream under stall");
        end
        in_valid = 1'b0;
      end
      begin
        for (int i = 0; i < 60; i++) begin
          tick();
          out_ready = (i % 4 != 1) && (i % 4 != 2);
        end
        out_ready = 1'b1;
      end
    join
    drain();
  endtask

  initial begin
    t_reset();
    t_latency();
    t_children();
    t_interval();
    t_leaf();
    t_stall();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule